// File: doc/BRIEF.md
# Circular-Index FIR Engine

This block computes one output of a finite impulse response filter each time it is started. It keeps a delay line of signed samples and a bank of signed coefficients in two internal register memories, both loaded through a single host write port. A run walks the delay line from a remembered starting position. The position wraps to zero after the last tap, while the coefficients are read in plain order from the first entry. The engine does one multiply-accumulate per cycle and reports the sum with a one-cycle done strobe.

The working position reached at the end of a run is stored as the starting position for the next run. Firmware that inserts new samples at the stored position therefore gets the usual sliding-window filter without moving any data. The host can also overwrite the stored position directly while the engine is idle.

Top module: `circ_fir_engine`

## Requirements
- R1: After reset the engine is idle (busy low), done is low, result is 0 and the stored start position (saved_idx) is 0.
- R2: Each run clears the accumulator and produces the sum over N taps of sample times coefficient. Samples and coefficients are 16-bit two's complement values, and the sum is a 40-bit two's complement value.
- R3: Tap i (i = 0..N-1) uses coefficient i and sample (s+i) mod N, where s is the start position of the run.
- R4: If the stored position is N or larger when a run loads it, the run starts at position 0.
- R5: At the end of a run the final working position is stored as saved_idx. It is visible from the cycle after done.
- R6: A start request while busy is high is ignored, including one in the done cycle.
- R7: done is high for exactly one cycle per run, and result holds the final sum in that cycle.
- R8: A run accepted at clock edge k keeps busy high for exactly N+2 cycles, with done in the last of them (edges k+1 .. k+N+2).
- R9: Write port selector codes: 0 writes sample[wr_addr], 1 writes coefficient[wr_addr], 2 writes the low 5 bits of wr_data to the stored position, and 3 does nothing. Sample and coefficient writes are taken in any cycle. A position write is taken only while idle and is ignored while busy.
- R10: A position write and a start in the same idle cycle are both taken, and that run starts from the newly written position.
- R11: The tap count is sampled from taps when a start is accepted. A value of 0 is treated as 1, and values above 32 are treated as 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Run request, taken only while idle |
| taps | input | 6 | Tap count N for the run |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 2 | Write target: 0 sample, 1 coefficient, 2 stored position |
| wr_addr | input | 5 | Sample or coefficient entry |
| wr_data | input | 16 | Write value |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle strobe, result valid |
| result | output | 40 | Accumulated sum |
| saved_idx | output | 5 | Stored start position |

## Verification
Two collisions are provoked. In the first, the host writes the stored position in the same idle cycle that a start arrives, and the run must begin from the new value. In the second, position writes and extra start requests arrive while a run is in flight, and they must leave both the run and the write-back untouched. A behavioural model in the bench follows every write and start clock by clock. Each cycle it judges busy, done, the result in the done cycle and the stored position against the model, and directed checks compare hand-computed sums.

// File: rtl/circ_fir_engine.sv
module circ_fir_engine #(
  parameter int DW   = 16,
  parameter int ACCW = 40,
  parameter int MAXN = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [$clog2(MAXN+1)-1:0] taps,
  input  logic                   wr_en,
  input  logic [1:0]             wr_sel,
  input  logic [$clog2(MAXN)-1:0] wr_addr,
  input  logic [DW-1:0]          wr_data,
  output logic                   busy,
  output logic                   done,
  output logic [ACCW-1:0]        result,
  output logic [$clog2(MAXN)-1:0] saved_idx
);
  localparam int IW = $clog2(MAXN);
  localparam int NW = $clog2(MAXN+1);
  localparam int PW = 2*DW;
  localparam logic [NW-1:0] NMAX = NW'(MAXN);
  localparam logic [NW-1:0] ONE  = NW'(1);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_ACC, S_WB} st_t;

  st_t st;
  logic signed [DW-1:0] dmem [MAXN];
  logic signed [DW-1:0] cmem [MAXN];
  logic [IW-1:0] sidx, widx, cidx;
  logic [NW-1:0] n_r;
  logic signed [ACCW-1:0] acc;

  wire [NW-1:0] n_eff = (taps == '0) ? ONE : ((taps > NMAX) ? NMAX : taps);
  wire signed [PW-1:0] prod = dmem[widx] * cmem[cidx];
  wire w_last = (NW'(widx) == n_r - ONE);
  wire c_last = (NW'(cidx) == n_r - ONE);

  assign busy      = (st != S_IDLE);
  assign done      = (st == S_WB);
  assign result    = acc;
  assign saved_idx = sidx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MAXN; i++) begin
        dmem[i] <= '0;
        cmem[i] <= '0;
      end
    end else if (wr_en) begin
      if (wr_sel == 2'd0) dmem[wr_addr] <= wr_data;
      if (wr_sel == 2'd1) cmem[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      sidx <= '0;
      widx <= '0;
      cidx <= '0;
      n_r  <= ONE;
      acc  <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (wr_en && wr_sel == 2'd2) sidx <= wr_data[IW-1:0];
          if (start) begin
            n_r <= n_eff;
            st  <= S_LOAD;
          end
        end
        S_LOAD: begin
          acc  <= '0;
          cidx <= '0;
          widx <= (NW'(sidx) >= n_r) ? '0 : sidx;
          st   <= S_ACC;
        end
        S_ACC: begin
          acc  <= acc + {{(ACCW-PW){prod[PW-1]}}, prod};
          widx <= w_last ? '0 : widx + 1'b1;
          cidx <= cidx + 1'b1;
          if (c_last) st <= S_WB;
        end
        default: begin
          sidx <= widx;
          st   <= S_IDLE;
        end
      endcase
    end
  end

  logic [NW:0] run_cyc;
  always_ff @(posedge clk) begin
    if (!rst_n || !busy) run_cyc <= '0;
    else                 run_cyc <= run_cyc + 1'b1;
  end

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_run_length_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_cyc == {1'b0, n_r} + (NW+1)'(1)));
  p_start_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (st != S_LOAD));
  p_index_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ACC) |-> (NW'(widx) < n_r));
  p_coef_from_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOAD) |=> (cidx == '0));
  p_clear_on_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOAD) |=> (acc == '0));
  p_hold_saved_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(saved_idx));
endmodule

// File: tb/circ_fir_engine_test.sv
`timescale 1ns/1ps
module circ_fir_engine_test;
  logic clk = 0, rst_n = 0, start = 0, wr_en = 0;
  logic [5:0] taps = 6'd1;
  logic [1:0] wr_sel = 0;
  logic [4:0] wr_addr = 0;
  logic [15:0] wr_data = 0;
  logic busy, done;
  logic [39:0] result;
  logic [4:0] saved_idx;

  circ_fir_engine uut (.clk, .rst_n, .start, .taps, .wr_en, .wr_sel, .wr_addr,
                       .wr_data, .busy, .done, .result, .saved_idx);

  always #2.5 clk = ~clk;

  int errs = 0, checks = 0;
  bit fin = 0, live = 0;
  string cur_req = "R2";

  int dm[32], cm[32];
  int ms, rem, exp_s;
  longint exp_res;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, expv, $time);
    end
  endtask

  // behavioural reference, updated on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      rem = 0; ms = 0; exp_res = 0; exp_s = 0;
      for (int i = 0; i < 32; i++) begin dm[i] = 0; cm[i] = 0; end
    end else begin
      if (wr_en) begin
        if (wr_sel == 0) dm[wr_addr] = int'($signed(wr_data));
        if (wr_sel == 1) cm[wr_addr] = int'($signed(wr_data));
        if (wr_sel == 2 && rem == 0) ms = int'(wr_data) & 31;
      end
      if (rem > 0) begin
        rem--;
        if (rem == 0) ms = exp_s;
      end else if (start) begin
        int n, s;
        n = (taps == 0) ? 1 : ((taps > 32) ? 32 : int'(taps));
        s = (ms >= n) ? 0 : ms;
        exp_res = 0;
        for (int i = 0; i < n; i++) begin
          exp_res += longint'(dm[s]) * longint'(cm[i]);
          s = (s + 1 == n) ? 0 : s + 1;
        end
        exp_s = s;
        rem = n + 2;
      end
    end
  end

  always @(negedge clk) begin
    if (live) begin
      check(busy == (rem > 0), "R8", "busy", busy, rem > 0);
      check(done == (rem == 1), "R7", "done", done, rem == 1);
      if (rem == 1)
        check($signed(result) == exp_res, cur_req, "result", $signed(result), exp_res);
      check(saved_idx == 5'(ms), "R5", "saved_idx", saved_idx, ms);
    end
  end

  task automatic wr(input logic [1:0] s, input logic [4:0] a, input logic [15:0] d);
    wr_en = 1; wr_sel = s; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic run(input int n, output longint r, output int cyc);
    taps = 6'(n); start = 1;
    @(negedge clk);
    start = 0;
    r = 0; cyc = 0;
    for (int k = 0; k < 100; k++) begin
      if (!busy) break;
      cyc++;
      if (done) r = $signed(result);
      @(negedge clk);
    end
  endtask

  initial begin
    longint r;
    int cyc, dcount;
    repeat (3) @(negedge clk);
    check(!busy && !done, "R1", "idle after reset", busy, 0);
    check(result == 0, "R1", "result after reset", result, 0);
    check(saved_idx == 0, "R1", "saved_idx after reset", saved_idx, 0);
    rst_n = 1;
    @(negedge clk);
    live = 1;

    for (int i = 0; i < 32; i++) wr(2'd0, 5'(i), 16'(i < 3 ? i + 1 : (i * 37 + 5) % 211 - 100));
    for (int i = 0; i < 32; i++) wr(2'd1, 5'(i), 16'(i < 3 ? 10 * (i + 1) : (i * 53) % 199 - 90));
    wr(2'd3, 5'd0, 16'h7fff);
    check(saved_idx == 0, "R9", "selector 3 no effect", saved_idx, 0);

    cur_req = "R2";
    run(3, r, cyc);
    check(r == 140, "R2", "3-tap sum from 0", r, 140);
    check(cyc == 5, "R8", "busy cycles N=3", cyc, 5);

    cur_req = "R3";
    wr(2'd2, 5'd0, 16'd1);
    run(3, r, cyc);
    check(r == 110, "R3", "3-tap sum from 1", r, 110);
    check(saved_idx == 1, "R5", "write-back after wrap", saved_idx, 1);

    cur_req = "R4";
    wr(2'd2, 5'd0, 16'd20);
    run(3, r, cyc);
    check(r == 140, "R4", "out-of-range start treated as 0", r, 140);
    check(saved_idx == 0, "R4", "write-back after out-of-range", saved_idx, 0);

    cur_req = "R5";
    wr(2'd2, 5'd0, 16'd5);
    run(7, r, cyc);
    check(saved_idx == 5, "R5", "saved after N=7", saved_idx, 5);
    run(4, r, cyc);
    check(saved_idx == 0, "R5", "saved after N=4 from 5", saved_idx, 0);

    cur_req = "R10";
    wr_en = 1; wr_sel = 2'd2; wr_data = 16'd1; taps = 6'd3; start = 1;
    @(negedge clk);
    wr_en = 0; start = 0;
    r = 0;
    for (int k = 0; k < 20 && busy; k++) begin
      if (done) r = $signed(result);
      @(negedge clk);
    end
    check(r == 110, "R10", "same-cycle write and start", r, 110);

    cur_req = "R6";
    dcount = 0;
    taps = 6'd5; start = 1;
    @(negedge clk);
    taps = 6'd9;
    for (int k = 0; k < 6; k++) begin
      if (done) dcount++;
      @(negedge clk);
    end
    start = 0;
    for (int k = 0; k < 40 && busy; k++) begin
      if (done) dcount++;
      @(negedge clk);
    end
    check(dcount == 1, "R6", "one run despite repeated start", dcount, 1);

    cur_req = "R9";
    wr(2'd2, 5'd2, 16'd2);
    taps = 6'd4; start = 1;
    @(negedge clk);
    start = 0;
    wr(2'd2, 5'd0, 16'd3);
    wr(2'd2, 5'd0, 16'd0);
    for (int k = 0; k < 20 && busy; k++) @(negedge clk);
    check(saved_idx == 2, "R9", "position write ignored while busy", saved_idx, 2);

    cur_req = "R11";
    wr(2'd2, 5'd0, 16'd0);
    run(0, r, cyc);
    check(r == 10, "R11", "zero taps as one", r, 10);
    check(cyc == 3, "R11", "busy cycles for zero taps", cyc, 3);
    run(40, r, cyc);
    check(cyc == 34, "R11", "taps above 32 clamped", cyc, 34);

    cur_req = "R2";
    for (int i = 0; i < 32; i++) begin
      wr(2'd0, 5'(i), 16'h8000);
      wr(2'd1, 5'(i), 16'h8000);
    end
    wr(2'd2, 5'd7, 16'd7);
    run(32, r, cyc);
    check(r == 64'sd34359738368, "R2", "full-scale negative products", r, 64'sd34359738368);
    for (int i = 0; i < 32; i++) wr(2'd0, 5'(i), 16'(i * 1000 - 16000));
    run(13, r, cyc);
    run(1, r, cyc);

    repeat (3) @(negedge clk);
    live = 0;
    fin = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      errs++; checks++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule